// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This block lets a pipeline run short if/else bodies as straight-line code instead of branching around them. A compare instruction presents two signed operands with a strobe. The unit records how the first operand relates to the second as four stored flags: equal, not-equal, less and greater.

Every instruction, compares included, carries a 4-bit condition selector. The unit tests that selector against the stored flags and raises an execute-enable. When the enable is low, the surrounding pipeline suppresses register writeback and any branch redirect, so the instruction retires as a no-op.

The enable is combinational from the stored flags and the selector. A compare changes the flags at the clock edge that ends its cycle. The instruction in the next cycle therefore already sees the new relation.

Top module: `pcu_cond_unit`

## Requirements
- R1: A synchronous active-low reset leaves the flags with only equal set. The flag output bit map is [0] equal, [1] not-equal, [2] less, [3] greater, so the reset value is 4'b0001.
- R2: A compare (cmp_valid high) whose own condition passes stores the relation of cmp_a to cmp_b. Exactly one of equal, less and greater is set, and not-equal is the inverse of equal.
- R3: Operands are compared as signed two's-complement values of DATA_W bits. For example, all-ones is less than 1, and the most negative value is less than the most positive.
- R4: A flag update becomes visible on flags_o, and in exec_en, in the cycle right after the compare. Within a cycle, exec_en follows cond_code combinationally from the stored flags.
- R5: A cycle with cmp_valid low leaves the flags unchanged, whatever its condition and operands.
- R6: Condition codes 0 (equal), 1 (not-equal), 2 (less) and 3 (greater) enable execution exactly when the corresponding flag is set.
- R7: Code 4 (less-or-equal) enables when less or equal is set. Code 5 (greater-or-equal) enables when greater or equal is set.
- R8: Code 14 (always) enables regardless of the flags. Code 15 (never) and the unassigned codes 6 to 13 never enable.
- R9: A compare whose own condition fails does not touch the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | The current instruction is a compare |
| cmp_a | input | DATA_W | First compare operand |
| cmp_b | input | DATA_W | Second compare operand |
| cond_code | input | 4 | Condition selector of the current instruction |
| exec_en | output | 1 | The current instruction may take effect |
| flags_o | output | 4 | Stored flags {greater, less, not-equal, equal} |

## Verification
The bench sweeps all sixteen condition codes against each of the three possible relations: equal after reset, greater after a compare of 7 with 3, and less after signed compares. Evaluating every code under each relation separates the combined codes (less-or-equal, greater-or-equal) from their single-flag parts.

Operand pairs that straddle the sign boundary (-1 against 1, and the most negative value against the most positive) tell signed ordering apart from unsigned ordering. A compare guarded by a failing condition, followed by one guarded by a passing condition, tells gated updates apart from unconditional ones.

A subtract-until-equal loop then chains compares, a greater-gated step, a less-or-equal-gated step and a not-equal loop test. This exercises back-to-back flag use, where one-cycle update visibility matters.

// File: rtl/pcu_pkg.sv
// Package: shared types and constants of the predicated execution condition unit.
// Assumes: condition codes are 4 bits wide; codes not named here never execute.
package pcu_pkg;

    // Stored relation; packed so that eq lands on bit 0 of the flag output.
    typedef struct packed {
        logic gt;
        logic lt;
        logic ne;
        logic eq;
    } flags_t;

    localparam int COND_W = 4;

    localparam logic [COND_W-1:0] CC_EQ = 4'd0;
    localparam logic [COND_W-1:0] CC_NE = 4'd1;
    localparam logic [COND_W-1:0] CC_LT = 4'd2;
    localparam logic [COND_W-1:0] CC_GT = 4'd3;
    localparam logic [COND_W-1:0] CC_LE = 4'd4;
    localparam logic [COND_W-1:0] CC_GE = 4'd5;
    localparam logic [COND_W-1:0] CC_AL = 4'd14;
    localparam logic [COND_W-1:0] CC_NV = 4'd15;

    localparam flags_t FLAGS_RESET = '{gt: 1'b0, lt: 1'b0, ne: 1'b0, eq: 1'b1};

endpackage

// File: rtl/pcu_compare.sv
// Module: pcu_compare
// Purpose: combinational relation of operand a to operand b as a flag vector.
// Assumes: SIGNED_CMP=1 selects two's-complement ordering, 0 selects unsigned.
module pcu_compare
    import pcu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit SIGNED_CMP = 1'b1
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output flags_t            rel
);

    logic is_eq;
    logic is_lt;

    // Equality does not depend on signedness.
    assign is_eq = (op_a == op_b);

    // Ordering variant picked by parameter.
    generate
        if (SIGNED_CMP) begin : g_signed
            assign is_lt = ($signed(op_a) < $signed(op_b));
        end else begin : g_unsigned
            assign is_lt = (op_a < op_b);
        end
    endgenerate

    // Pack the relation into the flag layout.
    always_comb begin
        rel.eq = is_eq;
        rel.ne = !is_eq;
        rel.lt = is_lt;
        rel.gt = !is_lt && !is_eq;
    end

endmodule

// File: rtl/pcu_cond_eval.sv
// Module: pcu_cond_eval
// Purpose: decode a condition selector against the stored flags into an enable.
// Assumes: codes outside the named set are treated as never-execute.
module pcu_cond_eval
    import pcu_pkg::*;
(
    input  flags_t              flags,
    input  logic [COND_W-1:0]   cond,
    output logic                enable
);

    // Condition decode; default covers reserved codes and never.
    always_comb begin
        unique case (cond)
            CC_EQ:   enable = flags.eq;
            CC_NE:   enable = flags.ne;
            CC_LT:   enable = flags.lt;
            CC_GT:   enable = flags.gt;
            CC_LE:   enable = flags.lt | flags.eq;
            CC_GE:   enable = flags.gt | flags.eq;
            CC_AL:   enable = 1'b1;
            default: enable = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_flag_reg.sv
// Module: pcu_flag_reg
// Purpose: holds the relational flags; loads a new relation when told to.
// Assumes: synchronous active-low reset; load is already qualified by the caller.
module pcu_flag_reg
    import pcu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);

    // Flag storage with reset to "equal only".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= FLAGS_RESET;
        end else if (load) begin
            q <= d;
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));  // R5

    AST_FLAGS_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.eq != q.ne) && ($countones({q.eq, q.lt, q.gt}) == 1));  // R2

endmodule

// File: rtl/pcu_cond_unit.sv
// Module: pcu_cond_unit (top)
// Purpose: predicated execution condition unit. Gates each instruction by its
//          condition code against flags that compare instructions set.
// Assumes: one instruction per cycle; a compare updates the flags only when its
//          own condition passes; the flags are visible to the next instruction.
module pcu_cond_unit
    import pcu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit SIGNED_CMP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [3:0]        cond_code,
    output logic              exec_en,
    output logic [3:0]        flags_o
);

    flags_t rel;
    flags_t flags_q;
    logic   flag_load;

    pcu_compare #(
        .DATA_W     (DATA_W),
        .SIGNED_CMP (SIGNED_CMP)
    ) u_compare (
        .op_a (cmp_a),
        .op_b (cmp_b),
        .rel  (rel)
    );

    pcu_cond_eval u_eval (
        .flags  (flags_q),
        .cond   (cond_code),
        .enable (exec_en)
    );

    // A compare only takes effect when its own condition passes.
    assign flag_load = cmp_valid & exec_en;

    pcu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .d     (rel),
        .q     (flags_q)
    );

    assign flags_o = flags_q;

    AST_RESET_EQ_ONLY: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 4'b0001));  // R1

    AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && exec_en && (cmp_a == cmp_b)) |=> (flags_o == 4'b0001));  // R2

    AST_GT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd3) |-> (exec_en == flags_o[3]));  // R6

    AST_LE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd4) |-> (exec_en == (flags_o[2] | flags_o[0])));  // R7

    AST_ALWAYS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd14) |-> exec_en);  // R8

    AST_NEVER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_code == 4'd15) || ((cond_code >= 4'd6) && (cond_code <= 4'd13))) |-> !exec_en);  // R8

    AST_SKIPPED_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !exec_en) |=> $stable(flags_o));  // R9

endmodule

// File: tb/pcu_cond_unit_tb.sv
// Scoreboard bench: drive() pushes expected enable/flags, a negedge monitor compares.
module pcu_cond_unit_tb;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_valid = 1'b0;
    logic [DATA_W-1:0] cmp_a = '0;
    logic [DATA_W-1:0] cmp_b = '0;
    logic [3:0]        cond_code = 4'd15;
    logic              exec_en;
    logic [3:0]        flags_o;

    int errors = 0;
    int checks = 0;

    bit        exp_en_q[$];
    logic [3:0] exp_fl_q[$];
    string     tag_q[$];

    logic [3:0] mflags = 4'b0001;  // bench model: [0]eq [1]ne [2]lt [3]gt

    always #10 clk = ~clk;  // 50 MHz

    pcu_cond_unit #(.DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .cond_code (cond_code),
        .exec_en   (exec_en),
        .flags_o   (flags_o)
    );

    function automatic bit model_en(input logic [3:0] cc, input logic [3:0] f);
        case (cc)
            4'd0:  return f[0];
            4'd1:  return f[1];
            4'd2:  return f[2];
            4'd3:  return f[3];
            4'd4:  return f[2] | f[0];
            4'd5:  return f[3] | f[0];
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] model_rel(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
        if (a == b) return 4'b0001;
        else if ($signed(a) < $signed(b)) return 4'b0110;
        else return 4'b1010;
    endfunction

    task automatic drive(input bit v, input logic [DATA_W-1:0] a,
                         input logic [DATA_W-1:0] b, input logic [3:0] cc, input string tag);
        bit e;
        @(posedge clk);
        #2;
        cmp_valid = v;
        cmp_a     = a;
        cmp_b     = b;
        cond_code = cc;
        e = model_en(cc, mflags);
        exp_en_q.push_back(e);
        exp_fl_q.push_back(mflags);
        tag_q.push_back(tag);
        if (v && e) mflags = model_rel(a, b);
    endtask

    // Monitor: pop one expected item per cycle and compare.
    always @(negedge clk) begin
        if (exp_en_q.size() > 0) begin
            bit         e;
            logic [3:0] f;
            string      t;
            e = exp_en_q.pop_front();
            f = exp_fl_q.pop_front();
            t = tag_q.pop_front();
            checks += 2;
            if (exec_en !== e) begin
                errors++;
                $display("FAIL %s exec_en actual=%b expected=%b", t, exec_en, e);
            end
            if (flags_o !== f) begin
                errors++;
                $display("FAIL %s flags actual=%b expected=%b", t, flags_o, f);
            end
        end
    end

    bit done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset with a compare pending: reset must dominate.
        cmp_valid = 1'b1; cmp_a = 5; cmp_b = 3; cond_code = 4'd14;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1; cmp_valid = 1'b0;

        // R1: reset state, equal only
        drive(0, 0, 0, 4'd14, "R1 reset flags");
        // R6/R7: codes under the equal relation
        for (int c = 0; c < 6; c++) drive(0, 0, 0, c[3:0], "R6 R7 codes on equal");

        // R2 R4: greater relation visible next cycle
        drive(1, 7, 3, 4'd14, "R2 compare 7 vs 3");
        drive(0, 0, 0, 4'd3, "R4 gt visible next cycle");
        for (int c = 0; c < 6; c++) drive(0, 0, 0, c[3:0], "R6 R7 codes on greater");

        // R5: non-compare cycles keep the flags
        drive(0, 1, 9, 4'd14, "R5 no compare, always");
        drive(0, 9, 9, 4'd2, "R5 no compare, failing");
        drive(0, 0, 0, 4'd14, "R5 flags kept");

        // R3: signed ordering
        drive(1, 32'hFFFF_FFFF, 1, 4'd14, "R3 -1 vs 1");
        drive(0, 0, 0, 4'd2, "R3 less after -1 vs 1");
        drive(1, 32'h8000_0000, 32'h7FFF_FFFF, 4'd14, "R3 min vs max");
        for (int c = 0; c < 6; c++) drive(0, 0, 0, c[3:0], "R6 R7 codes on less");

        // R9: gated compare with failing condition does not update
        drive(1, 9, 2, 4'd3, "R9 compare gated by gt fails");
        drive(0, 0, 0, 4'd14, "R9 flags untouched");
        drive(1, 2, 2, 4'd2, "R9 compare gated by lt passes");
        drive(0, 0, 0, 4'd0, "R2 equal after passing compare");

        // R8: always, never and reserved codes
        for (int c = 6; c < 16; c++) drive(0, 0, 0, c[3:0], "R8 always/never/reserved");
        drive(1, 4, 1, 4'd14, "R2 compare 4 vs 1");
        for (int c = 6; c < 16; c++) drive(0, 0, 0, c[3:0], "R8 codes on greater");

        // Subtract-until-equal loop: 12 and 18 meet at 6
        begin
            logic [DATA_W-1:0] i = 12;
            logic [DATA_W-1:0] j = 18;
            for (int k = 0; k < 20; k++) begin
                drive(1, i, j, 4'd14, "R2 loop compare");
                drive(0, i, j, 4'd3, "R6 loop gt step");
                if (model_en(4'd3, mflags)) i = i - j;
                drive(0, j, i, 4'd4, "R7 loop le step");
                if (model_en(4'd4, mflags)) j = j - i;
                drive(1, i, j, 4'd14, "R4 loop recompare");
                drive(0, 0, 0, 4'd1, "R6 loop ne test");
                if (!model_en(4'd1, mflags)) break;
            end
            checks++;
            if (i != 6) begin
                errors++;
                $display("FAIL R6 loop result actual=%0d expected=6", i);
            end
        end

        drive(0, 0, 0, 4'd15, "R8 final never");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule